// File: doc/BRIEF.md
# Synthesizer Register Writer with Commit Strobe

This block turns one register write request into a serial frame for a direct digital synthesis chip and then commits the new value with a separate update strobe. A request carries a register address, a data word and a length flag that picks a 32-bit or 64-bit payload. Every frame starts with an 8-bit write instruction holding the address. The payload follows, and every bit goes out most significant first. The serial clock runs at half the system clock rate.

Once the last bit has gone out, the chip select is released. After a programmable number of wait cycles, the update line is driven high for a fixed number of cycles. The wait lets the commit be placed against the synthesizer's internal timing. A one-cycle done flag marks the end of the commit. While a write is in flight the block reports busy, and it ignores any new request.

Top module: `dds_reg_commit`

## Requirements
- R1: After reset, and with no request, cs_n is 1, sclk is 0, io_upd is 0, busy is 0 and done is 0.
- R2: The first 8 serial bits form the instruction byte, sent bit 7 first. Bit 7 is 0 (write), bits 6:5 are 0 and bits 4:0 are req_addr.
- R3: The payload comes right after the instruction byte, most significant bit first. With req_long=1 it is all 64 bits of req_data, for a 72-bit frame. With req_long=0 it is req_data[31:0], for a 40-bit frame.
- R4: Each serial bit lasts two system cycles: sclk is low in the first cycle and high in the second. sdio changes only when sclk falls, so sdio is stable while sclk is high, and the device samples it on the rising edge.
- R5: A request is accepted on a clock edge where req_valid is 1 and the block is idle. cs_n goes low in the cycle that follows the accepting edge, which is one cycle before the first rising sclk edge. cs_n returns high one cycle after the final falling sclk edge.
- R6: sclk is 0 whenever cs_n is 1.
- R7: io_upd rises req_delay+1 cycles after cs_n rises, using the req_delay value captured when the request was accepted. It stays high for exactly 8 cycles, and only while cs_n is 1.
- R8: busy is 1 from the cycle after the accepting edge until io_upd falls. done is 1 for exactly one cycle, the one in which io_upd and busy have just fallen.
- R9: A request presented while busy is 1 is ignored. It changes neither the frame in progress nor the commit, and no further frame starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request, taken when idle |
| req_addr | input | 5 | Register address |
| req_data | input | 64 | Payload; bits 31:0 used for a short write |
| req_long | input | 1 | 1 = 64-bit payload, 0 = 32-bit payload |
| req_delay | input | 8 | Extra cycles between chip select release and update pulse |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle flag at the end of the commit |
| sclk | output | 1 | Serial clock |
| sdio | output | 1 | Serial data |
| cs_n | output | 1 | Active-low chip select |
| io_upd | output | 1 | Update strobe |

## Verification
The cycles are counted from the accepting edge, where cycle 0 is the cycle that edge starts. For a frame of N bits, bit k sits on sdio in cycles 2k and 2k+1, with sclk high in 2k+1, and cs_n is low from cycle 0 through cycle 2N. With a delay D, io_upd is high from cycle 2N+2+D through cycle 2N+9+D, busy is high through cycle 2N+9+D, and done is high in cycle 2N+10+D. The bench records every output at the falling clock edge of each cycle and compares the whole trace against these formulas. Later cycles of the trace confirm that an ignored request started nothing.

// File: rtl/dds_wr_pkg.sv
package dds_wr_pkg;
    localparam int INSTR_W = 8;

    typedef enum logic [1:0] {
        C_IDLE   = 2'd0,
        C_SHIFT  = 2'd1,
        C_COMMIT = 2'd2
    } ctrl_st_e;

    typedef enum logic [1:0] {
        U_IDLE  = 2'd0,
        U_WAIT  = 2'd1,
        U_PULSE = 2'd2
    } upd_st_e;
endpackage

// File: rtl/dds_wr_shifter.sv
module dds_wr_shifter #(
    parameter int FRAME_W = 72,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   nbits,
    output logic               sclk,
    output logic               sdio,
    output logic               shift_done
);
    typedef struct packed {
        logic [FRAME_W-1:0] sreg;
        logic [CNT_W-1:0]   left;
        logic               phase;
        logic               active;
        logic               sclk;
        logic               done;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (load) begin
            d.sreg   = frame;
            d.left   = nbits;
            d.phase  = 1'b0;
            d.active = 1'b1;
            d.sclk   = 1'b0;
        end else if (q.active) begin
            if (!q.phase) begin
                d.sclk  = 1'b1;
                d.phase = 1'b1;
            end else begin
                d.sclk  = 1'b0;
                d.phase = 1'b0;
                d.sreg  = q.sreg << 1;
                d.left  = q.left - CNT_W'(1);
                if (q.left == CNT_W'(1)) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk       = q.sclk;
    assign sdio       = q.sreg[FRAME_W-1];
    assign shift_done = q.done;
endmodule

// File: rtl/dds_wr_strobe.sv
module dds_wr_strobe
    import dds_wr_pkg::*;
#(
    parameter int DLY_W   = 8,
    parameter int PULSE_W = 8,
    localparam int PC_W   = (PULSE_W > 1) ? $clog2(PULSE_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DLY_W-1:0] delay,
    output logic             upd,
    output logic             last
);
    localparam logic [PC_W-1:0] P_LAST = PC_W'(PULSE_W - 1);

    typedef struct packed {
        upd_st_e          st;
        logic [DLY_W-1:0] dcnt;
        logic [PC_W-1:0]  pcnt;
        logic             upd;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            U_IDLE: begin
                if (start) begin
                    if (delay == '0) begin
                        d.st   = U_PULSE;
                        d.upd  = 1'b1;
                        d.pcnt = P_LAST;
                    end else begin
                        d.st   = U_WAIT;
                        d.dcnt = delay;
                    end
                end
            end
            U_WAIT: begin
                if (q.dcnt == DLY_W'(1)) begin
                    d.st   = U_PULSE;
                    d.upd  = 1'b1;
                    d.pcnt = P_LAST;
                end else begin
                    d.dcnt = q.dcnt - DLY_W'(1);
                end
            end
            U_PULSE: begin
                if (q.pcnt == '0) begin
                    d.st  = U_IDLE;
                    d.upd = 1'b0;
                end else begin
                    d.pcnt = q.pcnt - PC_W'(1);
                end
            end
            default: d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign upd  = q.upd;
    assign last = (q.st == U_PULSE) && (q.pcnt == '0);
endmodule

// File: rtl/dds_wr_ctrl.sv
module dds_wr_ctrl
    import dds_wr_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [DLY_W-1:0] req_delay,
    input  logic             shift_done,
    input  logic             upd_last,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output logic             cs_n,
    output logic             start,
    output logic [DLY_W-1:0] delay
);
    typedef struct packed {
        ctrl_st_e         st;
        logic             busy;
        logic             done;
        logic             cs_n;
        logic             start;
        logic [DLY_W-1:0] dly;
    } ctl_t;

    ctl_t q, d;

    assign accept = req_valid && (q.st == C_IDLE);

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.start = 1'b0;
        unique case (q.st)
            C_IDLE: begin
                if (accept) begin
                    d.st   = C_SHIFT;
                    d.busy = 1'b1;
                    d.cs_n = 1'b0;
                    d.dly  = req_delay;
                end
            end
            C_SHIFT: begin
                if (shift_done) begin
                    d.st    = C_COMMIT;
                    d.cs_n  = 1'b1;
                    d.start = 1'b1;
                end
            end
            C_COMMIT: begin
                if (upd_last) begin
                    d.st   = C_IDLE;
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            end
            default: d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy  = q.busy;
    assign done  = q.done;
    assign cs_n  = q.cs_n;
    assign start = q.start;
    assign delay = q.dly;
endmodule

// File: rtl/dds_reg_commit.sv
module dds_reg_commit
    import dds_wr_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 64,
    parameter int SHORT_W = 32,
    parameter int DLY_W   = 8,
    parameter int PULSE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_long,
    input  logic [DLY_W-1:0]  req_delay,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              sdio,
    output logic              cs_n,
    output logic              io_upd
);
    localparam int FRAME_W = INSTR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int PAD_I   = INSTR_W - 1 - ADDR_W;

    logic [INSTR_W-1:0] instr;
    logic [FRAME_W-1:0] long_frame, short_frame, frame;
    logic [CNT_W-1:0]   nbits;
    logic               accept, shift_done, upd_start, upd_last;
    logic [DLY_W-1:0]   dly_lat;

    assign instr      = {1'b0, {PAD_I{1'b0}}, req_addr};
    assign long_frame = {instr, req_data};

    generate
        if (DATA_W > SHORT_W) begin : g_pad
            assign short_frame = {instr, req_data[SHORT_W-1:0], {(DATA_W-SHORT_W){1'b0}}};
        end else begin : g_nopad
            assign short_frame = long_frame;
        end
    endgenerate

    assign frame = req_long ? long_frame : short_frame;
    assign nbits = req_long ? CNT_W'(FRAME_W) : CNT_W'(INSTR_W + SHORT_W);

    dds_wr_ctrl #(.DLY_W(DLY_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_delay (req_delay),
        .shift_done(shift_done),
        .upd_last  (upd_last),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .cs_n      (cs_n),
        .start     (upd_start),
        .delay     (dly_lat)
    );

    dds_wr_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .frame     (frame),
        .nbits     (nbits),
        .sclk      (sclk),
        .sdio      (sdio),
        .shift_done(shift_done)
    );

    dds_wr_strobe #(.DLY_W(DLY_W), .PULSE_W(PULSE_W)) u_strobe (
        .clk  (clk),
        .rst_n(rst_n),
        .start(upd_start),
        .delay(dly_lat),
        .upd  (io_upd),
        .last (upd_last)
    );
endmodule

// File: rtl/dds_reg_commit_chk.sv
module dds_reg_commit_chk #(
    parameter int PULSE_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic sclk,
    input logic sdio,
    input logic cs_n,
    input logic io_upd
);
    logic [15:0] hcnt;

    always_ff @(posedge clk) begin
        if (!rst_n)      hcnt <= '0;
        else if (io_upd) hcnt <= hcnt + 16'd1;
        else             hcnt <= '0;
    end

    a_r6_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    a_r4_sdio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && !cs_n) |-> $stable(sdio));

    a_r5_cs_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    a_r7_upd_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        io_upd |-> cs_n);

    a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_upd) |-> (hcnt == 16'(PULSE_W)));

    a_r8_upd_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        io_upd |-> busy);

    a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($fell(io_upd) && !busy));

    a_r8_busy_end_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind dds_reg_commit dds_reg_commit_chk #(.PULSE_W(PULSE_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .sclk  (sclk),
    .sdio  (sdio),
    .cs_n  (cs_n),
    .io_upd(io_upd)
);

// File: tb/dds_reg_commit_test.sv
module dds_reg_commit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [63:0] req_data = '0;
    logic        req_long = 1'b0;
    logic [7:0]  req_delay = '0;
    logic        busy, done, sclk, sdio, cs_n, io_upd;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic s_cs [0:511];
    logic s_ck [0:511];
    logic s_sd [0:511];
    logic s_up [0:511];
    logic s_bz [0:511];
    logic s_dn [0:511];

    always #5 clk = ~clk;

    dds_reg_commit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_long(req_long), .req_delay(req_delay),
        .busy(busy), .done(done), .sclk(sclk), .sdio(sdio), .cs_n(cs_n), .io_upd(io_upd)
    );

    function automatic logic [71:0] exp_frame(input logic [4:0] a, input logic [63:0] dat, input logic lng);
        logic [7:0] ins;
        ins = {1'b0, 2'b00, a};
        return lng ? {ins, dat} : {ins, dat[31:0], 32'h0};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cmp(input string tag, input int c, input logic act, input logic exp, inout bit bad);
        if (act !== exp && !bad) begin
            bad = 1;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, c, act, exp);
        end
    endtask

    task automatic run_write(input logic [4:0] a, input logic [63:0] dat, input logic lng,
                             input logic [7:0] dly, input bit intrude);
        int nb, len;
        logic [71:0] f;
        bit b2, b3, b4, b5, b6, b7, b8, b9;
        nb  = lng ? 72 : 40;
        len = 2 * nb + 12 + int'(dly);
        f   = exp_frame(a, dat, lng);
        b2 = 0; b3 = 0; b4 = 0; b5 = 0; b6 = 0; b7 = 0; b8 = 0; b9 = 0;
        @(negedge clk);
        req_addr = a; req_data = dat; req_long = lng; req_delay = dly; req_valid = 1'b1;
        @(posedge clk);
        for (int c = 0; c <= len; c++) begin
            @(negedge clk);
            s_cs[c] = cs_n; s_ck[c] = sclk; s_sd[c] = sdio;
            s_up[c] = io_upd; s_bz[c] = busy; s_dn[c] = done;
            if (c == 0) req_valid = 1'b0;
            if (intrude && c == 3) begin
                req_valid = 1'b1; req_addr = ~a; req_data = ~dat;
                req_long = ~lng; req_delay = 8'd0;
            end
            if (c == 2 * nb + 5) req_valid = 1'b0;
        end
        for (int c = 0; c <= len; c++) begin
            if (c < 2 * nb) begin
                if (c % 2 == 1) begin
                    if (c / 2 < 8) cmp("R2", c, s_sd[c], f[71 - c / 2], b2);
                    else           cmp("R3", c, s_sd[c], f[71 - c / 2], b3);
                end else begin
                    cmp("R4", c, s_sd[c], f[71 - c / 2], b4);
                end
            end
            cmp("R4", c, s_ck[c], (c < 2 * nb) && (c % 2 == 1), b4);
            cmp("R5", c, s_cs[c], !(c <= 2 * nb), b5);
            if (s_cs[c]) cmp("R6", c, s_ck[c], 1'b0, b6);
            cmp("R7", c, s_up[c], (c >= 2 * nb + 2 + int'(dly)) && (c <= 2 * nb + 9 + int'(dly)), b7);
            cmp("R8", c, s_bz[c], c <= 2 * nb + 9 + int'(dly), b8);
            cmp("R8", c, s_dn[c], c == 2 * nb + 10 + int'(dly), b8);
            if (c > 2 * nb + 10 + int'(dly)) begin
                cmp("R9", c, s_cs[c], 1'b1, b9);
                cmp("R9", c, s_bz[c], 1'b0, b9);
            end
        end
        check(!b2, "R2 instruction byte", 64'(b2), 64'd0);
        check(!b3, "R3 payload", 64'(b3), 64'd0);
        check(!b4, "R4 bit timing", 64'(b4), 64'd0);
        check(!b5, "R5 chip select window", 64'(b5), 64'd0);
        check(!b6, "R6 sclk idle", 64'(b6), 64'd0);
        check(!b7, "R7 update pulse", 64'(b7), 64'd0);
        check(!b8, "R8 busy/done", 64'(b8), 64'd0);
        check(!b9, "R9 ignored request", 64'(b9), 64'd0);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(cs_n === 1'b1, "R1 cs_n in reset", 64'(cs_n), 64'd1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cs_n === 1'b1, "R1 cs_n idle", 64'(cs_n), 64'd1);
        check(sclk === 1'b0, "R1 sclk idle", 64'(sclk), 64'd0);
        check(io_upd === 1'b0, "R1 io_upd idle", 64'(io_upd), 64'd0);
        check(busy === 1'b0, "R1 busy idle", 64'(busy), 64'd0);
        check(done === 1'b0, "R1 done idle", 64'(done), 64'd0);

        run_write(5'h07, 64'h0000_0000_1234_5678, 1'b0, 8'd0, 1'b0);
        run_write(5'h0E, 64'hFEDC_BA98_7654_3210, 1'b1, 8'd0, 1'b0);
        run_write(5'h1F, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 8'd1, 1'b0);
        run_write(5'h00, 64'h0, 1'b0, 8'd255, 1'b0);
        run_write(5'h15, 64'hA5A5_5A5A_C3C3_3C3C, 1'b1, 8'd3, 1'b1);
        run_write(5'h07, 64'hDEAD_BEEF_8000_0001, 1'b0, 8'd2, 1'b1);
        for (int i = 0; i < 30; i++) begin
            run_write(5'($urandom), {$urandom, $urandom}, 1'($urandom), 8'($urandom % 16), 1'($urandom));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule